// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block produces the status byte a flash device returns on reads while its internal controller is programming, erasing, suspended in an erase, or finished. It receives the operation mode from the command logic, a per-block mask of the blocks under erase, the block index of the current read address, the byte being programmed together with the cell content it lands on, a failure pulse from the controller, a read/reset clear, a block-erase command pulse and the read strobe. From these it builds the polling bit (7), a general toggle bit (6), a sticky error bit (5), an erase-window bit (3) and an address-sensitive toggle bit (2).

Both toggle bits advance only on the rising edge of the read strobe. Two consecutive reads therefore differ in a bit exactly when that bit is toggling. The error bit latches the failure until a read/reset clears it, and after an erase failure it remembers which blocks were involved, so that bit 2 singles them out. A counter measured in clock cycles holds bit 3 low for the erase-start window, and each new block-erase command restarts that window. Where a read must come from the array rather than from status, the block says so on a select output.

Top module: `fsb_status_gen`

## Requirements
- R1: Bit 6 inverts once at each rising edge of `rd_strb` while the mode is program, block erase, chip erase or suspend program. It holds its value while the strobe stays high and whenever the strobe does not rise. Mode encoding on `op_mode` is idle=0, program=1, block erase=2, chip erase=3, suspend read=4, suspend program=5.
- R2: Bit 7 reads 0 in block erase and chip erase. In program and suspend program it reads the inverse of `prog_data[7]`. In idle and suspend read it reads 1.
- R3: In block erase, bit 2 inverts on each strobe rise whose `rd_blk` selects a block with its `erase_mask` bit set, and reads 1 for other blocks. In chip erase, bit 2 inverts on every strobe rise, whatever the block.
- R4: In suspend read, a read of a block whose mask bit is set gives bit 7=1 and bit 6=1, bit 2 inverts on each strobe rise, and `arr_sel` is 0. A read of any other block sets `arr_sel` to 1 and leaves bit 6 unchanged.
- R5: While bit 5 is 0, bit 2 reads 1 in program, suspend program and idle.
- R6: Bit 5 becomes 1 in the cycle after `fail_pulse` is sampled high in program, block erase, chip erase or suspend program. It stays 1 until `clr_err` is sampled high, and `clr_err` takes priority.
- R7: In program or suspend program, bit 5 is set when `prog_data` has a 1 in a position where `cell_data` has a 0. A byte with no such bit leaves bit 5 at 0.
- R8: A failure in block erase records the mask of the blocks under erase, and a failure in chip erase records every block. While bit 5 is 1 in idle, program or suspend program, bit 2 inverts on strobe rises that address a recorded block and reads 1 elsewhere. `clr_err` forgets the record.
- R9: Bit 3 is 0 for exactly `WIN_CYC` clock cycles after `erase_cmd` is sampled high, and 1 otherwise. A new `erase_cmd` restarts the full window.
- R10: Bits 4, 1 and 0 read 0. `arr_sel` is 1 in idle while bit 5 is 0, and in a suspend read outside the masked blocks. It is 0 otherwise.
- R11: After reset, both toggle bits are 0, bit 5 is 0 and bit 3 is 1, so in idle the byte reads 0x8C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | Current operation mode (encoding in R1) |
| erase_mask | input | NUM_BLOCKS | One bit per block under erase or suspended in erase |
| rd_blk | input | $clog2(NUM_BLOCKS) | Block index of the read address |
| prog_data | input | 8 | Byte being programmed |
| cell_data | input | 8 | Current array content at the program address |
| fail_pulse | input | 1 | Controller reports a program or erase failure |
| clr_err | input | 1 | Read/reset command clears the error state |
| erase_cmd | input | 1 | A block-erase command was accepted |
| rd_strb | input | 1 | Read strobe; toggles advance on its rising edge |
| status_o | output | 8 | Status byte (bits 7, 6, 5, 3, 2 used) |
| arr_sel | output | 1 | Read should be served from the array |

## Verification
On every cycle the checker confirms these relations: each qualifying strobe rise inverts bit 6, bit 6 holds when no rise occurs, bit 7 is 0 in erase modes, bit 2 is 1 during an error-free program, the error bit stays set until cleared, the window bit drops right after an erase command, and suspended-block reads report 1 on bits 7 and 6 with the array deselected. Some behaviour shows only across a sequence of reads, so only the bench's directed scenarios can demonstrate it. That covers bit 2 separating erased blocks from untouched ones, the faulty-block memory surviving a return to idle, the illegal 0-to-1 program setting the error bit, and the window lasting exactly its cycle count and stretching when a command restarts it.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_PROG   = 3'd1,
      OP_BERASE = 3'd2,
      OP_CHIP   = 3'd3,
      OP_SUSP   = 3'd4,
      OP_SPROG  = 3'd5
   } op_mode_e;

   localparam int STAT_W = 8;
   localparam int B_POLL = 7;
   localparam int B_TOG  = 6;
   localparam int B_ERR  = 5;
   localparam int B_WIN  = 3;
   localparam int B_ATOG = 2;

   // Modes in which the controller is busy and the general toggle runs
   function automatic logic busy_mode(op_mode_e m);
      return (m == OP_PROG) || (m == OP_BERASE) || (m == OP_CHIP) || (m == OP_SPROG);
   endfunction

   function automatic logic prog_mode(op_mode_e m);
      return (m == OP_PROG) || (m == OP_SPROG);
   endfunction
endpackage

// File: rtl/fsb_toggle.sv
module fsb_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (step) q <= ~q;
   end
endmodule

// File: rtl/fsb_err_track.sv
module fsb_err_track
   import fsb_pkg::*;
#(
   parameter int NUM_BLOCKS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  op_mode_e              mode,
   input  logic                  fail_pulse,
   input  logic                  clr_err,
   input  logic [7:0]            prog_data,
   input  logic [7:0]            cell_data,
   input  logic [NUM_BLOCKS-1:0] erase_mask,
   output logic                  err,
   output logic [NUM_BLOCKS-1:0] fault_mask
);
   logic                  bad_bit;
   logic                  set_err;
   logic [NUM_BLOCKS-1:0] fault_add;

   always_comb begin
      // a 1 requested over a cell already at 0 cannot be programmed
      bad_bit = prog_mode(mode) && (|(prog_data & ~cell_data));
      set_err = (fail_pulse && busy_mode(mode)) || bad_bit;
      unique case (mode)
         OP_CHIP:   fault_add = fail_pulse ? '1 : '0;
         OP_BERASE: fault_add = fail_pulse ? erase_mask : '0;
         default:   fault_add = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err        <= 1'b0;
         fault_mask <= '0;
      end else if (clr_err) begin
         err        <= 1'b0;
         fault_mask <= '0;
      end else begin
         if (set_err) err <= 1'b1;
         fault_mask <= fault_mask | fault_add;
      end
   end
endmodule

// File: rtl/fsb_window_timer.sv
module fsb_window_timer #(
   parameter int WIN_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CNT_W = $clog2(WIN_CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (start)         cnt <= CNT_W'(WIN_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/fsb_status_gen.sv
module fsb_status_gen
   import fsb_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int WIN_CYC    = 100,
   localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            op_mode,
   input  logic [NUM_BLOCKS-1:0] erase_mask,
   input  logic [BLK_W-1:0]      rd_blk,
   input  logic [7:0]            prog_data,
   input  logic [7:0]            cell_data,
   input  logic                  fail_pulse,
   input  logic                  clr_err,
   input  logic                  erase_cmd,
   input  logic                  rd_strb,
   output logic [STAT_W-1:0]     status_o,
   output logic                  arr_sel
);
   localparam int N_TOG = 2;   // index 0: general toggle, index 1: address toggle

   if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_chk_blocks
      $error("NUM_BLOCKS must be a power of two of at least 2");
   end
   if (WIN_CYC < 1) begin : g_chk_win
      $error("WIN_CYC must be at least 1");
   end

   op_mode_e              mode;
   logic                  strb_q;
   logic                  rise;
   logic                  in_blk;
   logic                  in_fault;
   logic                  err;
   logic                  win_done;
   logic [NUM_BLOCKS-1:0] fault_mask;
   logic [N_TOG-1:0]      tog_run;
   logic [N_TOG-1:0]      tog_q;

   assign mode = op_mode_e'(op_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_q <= 1'b0;
      else        strb_q <= rd_strb;
   end
   assign rise = rd_strb & ~strb_q;

   assign in_blk   = erase_mask[rd_blk];
   assign in_fault = fault_mask[rd_blk];

   always_comb begin
      tog_run[0] = busy_mode(mode);
      unique case (mode)
         OP_BERASE, OP_SUSP: tog_run[1] = in_blk;
         OP_CHIP:            tog_run[1] = 1'b1;
         default:            tog_run[1] = err && in_fault;
      endcase
   end

   for (genvar g = 0; g < N_TOG; g++) begin : g_tog
      fsb_toggle u_tog (
         .clk   (clk),
         .rst_n (rst_n),
         .step  (tog_run[g] & rise),
         .q     (tog_q[g])
      );
   end

   fsb_err_track #(.NUM_BLOCKS(NUM_BLOCKS)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .fail_pulse (fail_pulse),
      .clr_err    (clr_err),
      .prog_data  (prog_data),
      .cell_data  (cell_data),
      .erase_mask (erase_mask),
      .err        (err),
      .fault_mask (fault_mask)
   );

   fsb_window_timer #(.WIN_CYC(WIN_CYC)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .start (erase_cmd),
      .done  (win_done)
   );

   always_comb begin
      status_o = '0;
      unique case (mode)
         OP_PROG, OP_SPROG:  status_o[B_POLL] = ~prog_data[7];
         OP_BERASE, OP_CHIP: status_o[B_POLL] = 1'b0;
         default:            status_o[B_POLL] = 1'b1;
      endcase
      status_o[B_TOG]  = (mode == OP_SUSP && in_blk) ? 1'b1 : tog_q[0];
      status_o[B_ERR]  = err;
      status_o[B_WIN]  = win_done;
      status_o[B_ATOG] = tog_run[1] ? tog_q[1] : 1'b1;
      arr_sel = ((mode == OP_IDLE) && !err) || ((mode == OP_SUSP) && !in_blk);
   end
endmodule

// File: rtl/fsb_status_chk.sv
module fsb_status_chk
   import fsb_pkg::*;
#(
   parameter int NUM_BLOCKS = 16,
   parameter int BLK_W      = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [2:0]            op_mode,
   input logic [NUM_BLOCKS-1:0] erase_mask,
   input logic [BLK_W-1:0]      rd_blk,
   input logic                  clr_err,
   input logic                  erase_cmd,
   input logic                  rd_strb,
   input logic [7:0]            status_o,
   input logic                  arr_sel
);
   logic strb_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_prev <= 1'b0;
      else        strb_prev <= rd_strb;
   end

   logic busy;
   assign busy = busy_mode(op_mode_e'(op_mode));

   p_dq6_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strb && !strb_prev && busy) |=>
         ((op_mode != $past(op_mode)) || (status_o[6] != $past(status_o[6]))));

   p_dq6_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_strb && !strb_prev) && busy) |=>
         ((op_mode != $past(op_mode)) || $stable(status_o[6])));

   p_dq7_erase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_mode == OP_BERASE) || (op_mode == OP_CHIP)) |-> !status_o[7]);

   p_susp_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_mode == OP_SUSP) && erase_mask[rd_blk]) |-> (status_o[7] && status_o[6] && !arr_sel));

   p_dq2_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_mode == OP_PROG) && !status_o[5]) |-> status_o[2]);

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[5] && !clr_err) |=> status_o[5]);

   p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_err |=> !status_o[5]);

   p_win_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      erase_cmd |=> !status_o[3]);
endmodule

bind fsb_status_gen fsb_status_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) i_fsb_status_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_mode    (op_mode),
   .erase_mask (erase_mask),
   .rd_blk     (rd_blk),
   .clr_err    (clr_err),
   .erase_cmd  (erase_cmd),
   .rd_strb    (rd_strb),
   .status_o   (status_o),
   .arr_sel    (arr_sel)
);

// File: tb/test_fsb_status_gen.sv
module test_fsb_status_gen;
   import fsb_pkg::*;

   localparam int NB  = 8;
   localparam int BW  = 3;
   localparam int WIN = 40;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    op_mode;
   logic [NB-1:0] erase_mask;
   logic [BW-1:0] rd_blk;
   logic [7:0]    prog_data, cell_data;
   logic          fail_pulse, clr_err, erase_cmd, rd_strb;
   logic [7:0]    status_o;
   logic          arr_sel;

   always #2 clk = ~clk;   // 250 MHz

   fsb_status_gen #(.NUM_BLOCKS(NB), .WIN_CYC(WIN)) i_fsb_status_gen (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .erase_mask(erase_mask),
      .rd_blk(rd_blk), .prog_data(prog_data), .cell_data(cell_data),
      .fail_pulse(fail_pulse), .clr_err(clr_err), .erase_cmd(erase_cmd),
      .rd_strb(rd_strb), .status_o(status_o), .arr_sel(arr_sel)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench-side model state
   bit          m6, m2, merr;
   logic [NB-1:0] mfault;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit t2_runs(int blk);
      case (op_mode_e'(op_mode))
         OP_BERASE, OP_SUSP: return erase_mask[blk];
         OP_CHIP:            return 1'b1;
         default:            return merr && mfault[blk];
      endcase
   endfunction

   function automatic logic [7:0] expv(int blk);
      logic [7:0] e;
      op_mode_e m = op_mode_e'(op_mode);
      e = 8'h00;
      e[7] = (m == OP_PROG || m == OP_SPROG) ? ~prog_data[7] :
             (m == OP_BERASE || m == OP_CHIP) ? 1'b0 : 1'b1;
      e[6] = (m == OP_SUSP && erase_mask[blk]) ? 1'b1 : m6;
      e[5] = merr;
      e[3] = 1'b1;
      e[2] = t2_runs(blk) ? m2 : 1'b1;
      return e;
   endfunction

   // one read: strobe high for hold_cyc cycles, check after the rise and while held
   task automatic do_read(int blk, string req, int hold_cyc = 1);
      op_mode_e m = op_mode_e'(op_mode);
      @(negedge clk);
      rd_blk = BW'(blk);
      rd_strb = 1'b1;
      if (m == OP_PROG || m == OP_BERASE || m == OP_CHIP || m == OP_SPROG) m6 = ~m6;
      if (t2_runs(blk)) m2 = ~m2;
      for (int i = 0; i < hold_cyc; i++) begin
         @(negedge clk);
         chk(req, status_o, expv(blk));
      end
      rd_strb = 1'b0;
   endtask

   task automatic set_mode(op_mode_e m);
      @(negedge clk);
      op_mode = m;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R11 reset byte", status_o, 8'h8C);
      chk("R10 idle arr_sel", arr_sel, 1);
   endtask

   task automatic t_program();
      set_mode(OP_PROG);
      prog_data = 8'h80;
      do_read(0, "R1 R2 R5 program read a");
      do_read(0, "R1 R2 R5 program read b");
      prog_data = 8'h00;
      do_read(3, "R2 program bit7 inverted");
      chk("R10 program arr_sel", arr_sel, 0);
      do_read(3, "R1 strobe held high no extra toggle", 4);
   endtask

   task automatic t_block_erase();
      erase_mask = 8'b0000_0110;
      set_mode(OP_BERASE);
      do_read(1, "R3 erased block toggles a");
      do_read(1, "R3 erased block toggles b");
      do_read(2, "R3 second erased block");
      do_read(5, "R3 unerased block reads 1");
      do_read(5, "R3 unerased block again");
   endtask

   task automatic t_chip_erase();
      erase_mask = '0;
      set_mode(OP_CHIP);
      do_read(0, "R3 chip erase block 0");
      do_read(7, "R3 chip erase block 7");
   endtask

   task automatic t_suspend();
      erase_mask = 8'b0000_0010;
      set_mode(OP_SUSP);
      do_read(1, "R4 suspended block a");
      chk("R4 suspended block arr_sel", arr_sel, 0);
      do_read(1, "R4 suspended block b");
      do_read(4, "R4 outside suspended block");
      chk("R4 R10 outside arr_sel", arr_sel, 1);
      set_mode(OP_SPROG);
      prog_data = 8'h7F;
      do_read(4, "R1 R2 R5 suspend program a");
      do_read(4, "R1 R5 suspend program b");
   endtask

   task automatic t_erase_fail();
      erase_mask = 8'b0000_1000;
      set_mode(OP_BERASE);
      fail_pulse = 1'b1;
      @(negedge clk);
      fail_pulse = 1'b0;
      merr = 1; mfault = 8'b0000_1000;
      op_mode = OP_IDLE;
      erase_mask = '0;
      chk("R6 error set after fail", status_o[5], 1);
      chk("R10 idle with error arr_sel", arr_sel, 0);
      do_read(3, "R8 faulty block toggles a");
      do_read(3, "R8 faulty block toggles b");
      do_read(0, "R8 healthy block reads 1");
      repeat (5) @(negedge clk);
      chk("R6 error sticky", status_o[5], 1);
      clr_err = 1'b1;
      @(negedge clk);
      clr_err = 1'b0;
      merr = 0; mfault = '0;
      chk("R6 clear by read/reset", status_o[5], 0);
      do_read(3, "R8 record forgotten after clear");
   endtask

   task automatic t_bad_program();
      set_mode(OP_PROG);
      cell_data = 8'hF0;
      prog_data = 8'h30;        // only clears bits: legal
      @(negedge clk);
      chk("R7 legal program no error", status_o[5], 0);
      prog_data = 8'h31;        // bit 0 would go 0->1
      @(negedge clk);
      merr = 1;
      prog_data = 8'h30;
      chk("R7 illegal program sets error", status_o[5], 1);
      do_read(2, "R7 R5 program read with error");
      set_mode(OP_CHIP);
      fail_pulse = 1'b1;
      clr_err = 1'b1;
      @(negedge clk);
      fail_pulse = 1'b0;
      clr_err = 1'b0;
      merr = 0;
      chk("R6 clear has priority over fail", status_o[5], 0);
      cell_data = 8'hFF;
      set_mode(OP_IDLE);
   endtask

   task automatic t_window();
      int lo;
      @(negedge clk);
      chk("R9 window idle high", status_o[3], 1);
      erase_cmd = 1'b1;
      @(negedge clk);
      erase_cmd = 1'b0;
      lo = 0;
      while (status_o[3] == 1'b0 && lo < 1000) begin
         lo++;
         @(negedge clk);
      end
      chk("R9 window length", lo, WIN);
      erase_cmd = 1'b1;
      @(negedge clk);
      erase_cmd = 1'b0;
      repeat (10) @(negedge clk);
      erase_cmd = 1'b1;
      @(negedge clk);
      erase_cmd = 1'b0;
      lo = 0;
      while (status_o[3] == 1'b0 && lo < 1000) begin
         lo++;
         @(negedge clk);
      end
      chk("R9 window restarted", lo, WIN);
   endtask

   initial begin
      rst_n = 1'b0; op_mode = OP_IDLE; erase_mask = '0; rd_blk = '0;
      prog_data = 8'h00; cell_data = 8'hFF; fail_pulse = 0; clr_err = 0;
      erase_cmd = 0; rd_strb = 0;
      m6 = 0; m2 = 0; merr = 0; mfault = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_block_erase();
      t_chip_erase();
      t_suspend();
      set_mode(OP_IDLE);
      t_erase_fail();
      t_bad_program();
      t_window();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule